// File: doc/BRIEF.md
# Grouped Commit Register File

This block is a small register file on a 32-bit register write bus. Three of its registers are buffered: a software write to one of them, including a write that sets only some bytes, lands in that register's own holding buffer and leaves the live value unchanged. The fourth register is an ordinary register. It is written directly and can also serve as the commit strobe.

Pending buffers are released together by a single commit event. A parameter selects the source of that event. It is either a software write to the ordinary register or an external single-bit hardware input whose active level is also set by a parameter. On the commit edge, every buffered register that holds pending data takes its buffered value in the same clock cycle. A register with nothing pending keeps its value.

Each live register value goes to the hardware side, together with a one-cycle pulse that marks a software-originated update. For a buffered register, that pulse fires only at commit, never at the write.

Top module: `grpcommit_regfile`

## Requirements
- R1: During and after synchronous active-high reset, all register values, all buffers, all pending flags, `hw_swmod` and `bus_rdata` are 0.
- R2: A write to a buffered register (address 0, 1 or 2, with `bus_we` high and at least one strobe bit set) does not change that register's value on `hw_value` or `bus_rdata` before a commit.
- R3: Strobe bit k of `bus_wstrb` enables data bits 8k+7..8k. Successive writes to one buffered register merge into its buffer, and bytes that were not written keep their earlier content.
- R4: With `TRIG_SRC = TRIG_FROM_REG`, a write to address 3 with at least one strobe bit set is the commit event. Address 3 itself takes its strobed bytes on that write, and `hw_swmod[3]` pulses in the following cycle.
- R5: With `TRIG_SRC = TRIG_FROM_PIN`, `hw_trig` at its active level (high when `TRIG_ACT_HIGH` is 1, low when it is 0) is the commit event. The committed value appears on `hw_value` in the cycle after `hw_trig` is sampled active.
- R6: On a commit event, every buffered register with pending data updates in the same clock cycle, and their `hw_swmod` bits pulse together.
- R7: A buffered register with no pending data ignores a commit event: its value is unchanged and its `hw_swmod` bit stays 0.
- R8: `hw_swmod[i]` for a buffered register is a single-cycle pulse in the cycle after a commit of that register. It stays 0 after a write that is still only buffered.
- R9: If a buffered write and a commit event fall in the same cycle, only the data pending before that cycle is committed. The new write stays pending and is committed by the next event.
- R10: Each buffered register has independent buffer and pending state. A write to one never alters another's buffer or causes another to commit.
- R11: `bus_rdata` returns, one cycle after `bus_addr` is presented, the live value of the addressed register.
- R12: In pin mode, a write to address 3 updates only address 3 and commits nothing. In register mode, `hw_trig` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write request for this cycle |
| bus_addr | input | ADDR_W | Register index (0..2 buffered, 3 ordinary) |
| bus_wdata | input | DATA_W | Write data |
| bus_wstrb | input | DATA_W/8 | Byte enables |
| bus_rdata | output | DATA_W | Registered read data of the addressed register |
| hw_trig | input | 1 | External commit input, level set by TRIG_ACT_HIGH |
| hw_value | output | NUM_REGS*DATA_W | Live values, register i at bits i*DATA_W upward |
| hw_swmod | output | NUM_REGS | One-cycle software-update pulse per register |

## Verification
The bound checker checks the following on every cycle:
- a buffered value moves only in the cycle after a commit that found it pending;
- each modify pulse follows such a commit, or, for the ordinary register, a write to it;
- a write always leaves its slot pending;
- a commit without a simultaneous write clears the pending flag.

Byte merging across several partial writes, the exact committed data, the same-cycle write-and-commit ordering, and polarity handling in pin mode depend on concrete data sequences. The bench shows those with two instances, one per trigger source with the pin active low. Both instances are fed the same bus and trigger and are compared against a behavioural model on every clock.

// File: rtl/gc_pkg.sv
package gc_pkg;
  typedef enum logic {
    TRIG_FROM_REG = 1'b0,
    TRIG_FROM_PIN = 1'b1
  } trig_src_e;
endpackage

// File: rtl/gc_byte_merge.sv
module gc_byte_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   old_i,
  input  logic [DATA_W-1:0]   new_i,
  input  logic [DATA_W/8-1:0] strb_i,
  output logic [DATA_W-1:0]   merged_o
);
  localparam int LANES = DATA_W / 8;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged_o[b*8 +: 8] = strb_i[b] ? new_i[b*8 +: 8] : old_i[b*8 +: 8];
  end
endmodule

// File: rtl/gc_trig_sel.sv
module gc_trig_sel
  import gc_pkg::*;
#(
  parameter trig_src_e TRIG_SRC      = TRIG_FROM_REG,
  parameter bit        TRIG_ACT_HIGH = 1'b1
) (
  input  logic trig_reg_wr_i,
  input  logic hw_trig_i,
  output logic fire_o
);
  logic pin_active;

  assign pin_active = TRIG_ACT_HIGH ? hw_trig_i : ~hw_trig_i;
  assign fire_o     = (TRIG_SRC == TRIG_FROM_REG) ? trig_reg_wr_i : pin_active;
endmodule

// File: rtl/gc_buf_slot.sv
module gc_buf_slot #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] wstrb_i,
  input  logic                fire_i,
  output logic [DATA_W-1:0]   val_o,
  output logic                swmod_o,
  output logic                pend_o
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] hold_nxt;
  logic              commit;

  gc_byte_merge #(.DATA_W(DATA_W)) u_merge (
    .old_i    (hold_q),
    .new_i    (wdata_i),
    .strb_i   (wstrb_i),
    .merged_o (hold_nxt)
  );

  // Only data pending before this edge is released; a write arriving on
  // the same edge lands in the buffer and stays pending.
  assign commit = fire_i & pend_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      val_o   <= '0;
      pend_o  <= 1'b0;
      swmod_o <= 1'b0;
    end else begin
      swmod_o <= commit;
      if (commit) val_o <= hold_q;
      if (wr_i) begin
        hold_q <= hold_nxt;
        pend_o <= 1'b1;
      end else if (commit) begin
        pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gc_plain_reg.sv
module gc_plain_reg #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] wstrb_i,
  output logic [DATA_W-1:0]   val_o,
  output logic                swmod_o
);
  logic [DATA_W-1:0] val_nxt;

  gc_byte_merge #(.DATA_W(DATA_W)) u_merge (
    .old_i    (val_o),
    .new_i    (wdata_i),
    .strb_i   (wstrb_i),
    .merged_o (val_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      val_o   <= '0;
      swmod_o <= 1'b0;
    end else begin
      swmod_o <= wr_i;
      if (wr_i) val_o <= val_nxt;
    end
  end
endmodule

// File: rtl/grpcommit_regfile.sv
module grpcommit_regfile
  import gc_pkg::*;
#(
  parameter int        DATA_W        = 32,
  parameter int        NUM_BUF       = 3,
  parameter int        ADDR_W        = $clog2(NUM_BUF + 1),
  parameter trig_src_e TRIG_SRC      = TRIG_FROM_REG,
  parameter bit        TRIG_ACT_HIGH = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_we,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic [DATA_W/8-1:0]            bus_wstrb,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic                           hw_trig,
  output logic [(NUM_BUF+1)*DATA_W-1:0]  hw_value,
  output logic [NUM_BUF:0]               hw_swmod
);
  localparam int NUM_REGS = NUM_BUF + 1;
  localparam int TRIG_IDX = NUM_BUF;

  logic [NUM_REGS-1:0] wr_hit;
  logic [NUM_BUF-1:0]  pend_vec;
  logic [DATA_W-1:0]   reg_val [NUM_REGS];
  logic                trig_fire;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign wr_hit[i] = bus_we && (int'(bus_addr) == i) && (|bus_wstrb);
  end

  gc_trig_sel #(
    .TRIG_SRC      (TRIG_SRC),
    .TRIG_ACT_HIGH (TRIG_ACT_HIGH)
  ) u_trig (
    .trig_reg_wr_i (wr_hit[TRIG_IDX]),
    .hw_trig_i     (hw_trig),
    .fire_o        (trig_fire)
  );

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
    gc_buf_slot #(.DATA_W(DATA_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_i    (wr_hit[i]),
      .wdata_i (bus_wdata),
      .wstrb_i (bus_wstrb),
      .fire_i  (trig_fire),
      .val_o   (reg_val[i]),
      .swmod_o (hw_swmod[i]),
      .pend_o  (pend_vec[i])
    );
  end

  gc_plain_reg #(.DATA_W(DATA_W)) u_trig_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (wr_hit[TRIG_IDX]),
    .wdata_i (bus_wdata),
    .wstrb_i (bus_wstrb),
    .val_o   (reg_val[TRIG_IDX]),
    .swmod_o (hw_swmod[TRIG_IDX])
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_out
    assign hw_value[i*DATA_W +: DATA_W] = reg_val[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (int'(bus_addr) < NUM_REGS) begin
      bus_rdata <= reg_val[bus_addr];
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/gc_regfile_chk.sv
module gc_regfile_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_BUF = 3
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          fire,
  input logic [NUM_BUF-1:0]            pend,
  input logic [NUM_BUF:0]              wr_hit,
  input logic [(NUM_BUF+1)*DATA_W-1:0] hw_value,
  input logic [NUM_BUF:0]              hw_swmod
);
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot_chk
    // R2 R7
    value_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !($past(fire) && $past(pend[i])))
        |-> $stable(hw_value[i*DATA_W +: DATA_W]));

    // R8
    swmod_at_commit_chk: assert property (@(posedge clk) disable iff (rst)
      hw_swmod[i] |-> ($past(fire) && $past(pend[i])));

    // R10
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
      wr_hit[i] |=> pend[i]);

    // R9
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (fire && pend[i] && !wr_hit[i]) |=> !pend[i]);
  end

  // R6
  group_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && (pend != '0)) |=> (hw_swmod[NUM_BUF-1:0] == $past(pend)));

  // R4
  trig_reg_swmod_chk: assert property (@(posedge clk) disable iff (rst)
    hw_swmod[NUM_BUF] |-> $past(wr_hit[NUM_BUF]));
endmodule

bind grpcommit_regfile gc_regfile_chk #(
  .DATA_W  (DATA_W),
  .NUM_BUF (NUM_BUF)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fire     (trig_fire),
  .pend     (pend_vec),
  .wr_hit   (wr_hit),
  .hw_value (hw_value),
  .hw_swmod (hw_swmod)
);

// File: tb/tb_grpcommit_regfile.sv
module tb_grpcommit_regfile;
  import gc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        trig = 1'b1;  // pin instance is active low: 1 is idle
  logic [31:0] rd_r, rd_e;
  logic [127:0] hv_r, hv_e;
  logic [3:0]  sw_r, sw_e;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  grpcommit_regfile #(.TRIG_SRC(TRIG_FROM_REG), .TRIG_ACT_HIGH(1'b1)) dut (
    .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wstrb(wstrb), .bus_rdata(rd_r), .hw_trig(trig),
    .hw_value(hv_r), .hw_swmod(sw_r));

  grpcommit_regfile #(.TRIG_SRC(TRIG_FROM_PIN), .TRIG_ACT_HIGH(1'b0)) dut_ext (
    .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wstrb(wstrb), .bus_rdata(rd_e), .hw_trig(trig),
    .hw_value(hv_e), .hw_swmod(sw_e));

  // Behavioural model: index 0 = register-triggered, 1 = pin-triggered (active low)
  logic [31:0] m_val [2][4];
  logic [31:0] m_buf [2][3];
  bit          m_pend[2][3];
  logic [3:0]  m_sw  [2];
  logic [31:0] m_rd  [2];

  function automatic logic [31:0] apply_bytes(logic [31:0] base, logic [31:0] d, logic [3:0] s);
    logic [31:0] r = base;
    for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (rst) begin
        for (int k = 0; k < 4; k++) m_val[c][k] = '0;
        for (int k = 0; k < 3; k++) begin m_buf[c][k] = '0; m_pend[c][k] = 0; end
        m_sw[c] = '0;
        m_rd[c] = '0;
      end else begin
        bit wr_ok, fire;
        wr_ok = we && (wstrb != 0);
        fire = (c == 0) ? (wr_ok && addr == 2'd3) : (trig == 1'b0);
        m_rd[c] = m_val[c][addr];
        m_sw[c] = '0;
        for (int k = 0; k < 3; k++) begin
          if (fire && m_pend[c][k]) begin
            m_val[c][k] = m_buf[c][k];
            m_sw[c][k] = 1'b1;
            m_pend[c][k] = 0;
          end
          if (wr_ok && addr == k) begin
            m_buf[c][k] = apply_bytes(m_buf[c][k], wdata, wstrb);
            m_pend[c][k] = 1;
          end
        end
        if (wr_ok && addr == 2'd3) begin
          m_val[c][3] = apply_bytes(m_val[c][3], wdata, wstrb);
          m_sw[c][3] = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < 4; k++) begin
        chk("model reg-mode value", hv_r[32*k +: 32], m_val[0][k]);
        chk("model pin-mode value", hv_e[32*k +: 32], m_val[1][k]);
      end
      chk("model reg-mode swmod", {28'd0, sw_r}, {28'd0, m_sw[0]});
      chk("model pin-mode swmod", {28'd0, sw_e}, {28'd0, m_sw[1]});
      chk("model reg-mode rdata", rd_r, m_rd[0]);
      chk("model pin-mode rdata", rd_e, m_rd[1]);
    end
  end

  task automatic step(input logic w, input logic [1:0] a, input logic [31:0] d,
                      input logic [3:0] s, input logic t);
    @(negedge clk);
    we = w; addr = a; wdata = d; wstrb = s; trig = t;
  endtask

  task automatic idle();
    @(negedge clk);
    we = 1'b0; wstrb = '0; trig = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset value reg-mode", hv_r[31:0] | hv_r[63:32] | hv_r[95:64] | hv_r[127:96], 32'h0);
    chk("R1 reset swmod", {28'd0, sw_r | sw_e}, 32'h0);
    rst = 1'b0;
    idle();

    step(1, 2'd0, 32'h1122_3344, 4'hF, 1);
    step(1, 2'd1, 32'hAABB_CCDD, 4'b0011, 1);
    step(1, 2'd1, 32'h5566_7788, 4'b1100, 1);
    idle();
    chk("R2 buffered write hidden reg-mode", hv_r[31:0], 32'h0);
    chk("R2 buffered write hidden pin-mode", hv_e[31:0], 32'h0);
    chk("R8 no swmod at write", {28'd0, sw_r | sw_e}, 32'h0);

    step(1, 2'd3, 32'hCAFE_0001, 4'hF, 1);
    idle();
    chk("R4 commit by reg write val0", hv_r[31:0], 32'h1122_3344);
    chk("R3 merged bytes val1", hv_r[63:32], 32'h5566_CCDD);
    chk("R7 unwritten val2 kept", hv_r[95:64], 32'h0);
    chk("R4 trigger reg own value", hv_r[127:96], 32'hCAFE_0001);
    chk("R6 group swmod", {28'd0, sw_r}, 32'hB);
    chk("R12 pin mode ignores reg write", hv_e[31:0], 32'h0);
    chk("R12 pin mode swmod only reg3", {28'd0, sw_e}, 32'h8);
    idle();
    chk("R8 single-cycle pulse", {28'd0, sw_r}, 32'h0);

    step(0, 2'd0, 32'h0, 4'h0, 0);
    idle();
    chk("R5 pin commit val0 next cycle", hv_e[31:0], 32'h1122_3344);
    chk("R5 pin commit val1", hv_e[63:32], 32'h5566_CCDD);
    chk("R6 pin group swmod", {28'd0, sw_e}, 32'h3);
    chk("R12 reg mode ignores hw_trig", {28'd0, sw_r}, 32'h0);

    step(1, 2'd2, 32'h0101_0101, 4'hF, 1);
    step(1, 2'd2, 32'h0202_0202, 4'b0001, 0);
    idle();
    chk("R9 old data committed", hv_e[95:64], 32'h0101_0101);
    chk("R9 swmod slot2", {28'd0, sw_e}, 32'h4);
    step(0, 2'd0, 32'h0, 4'h0, 0);
    idle();
    chk("R9 late write committed next", hv_e[95:64], 32'h0101_0102);

    step(1, 2'd0, 32'hA5A5_A5A5, 4'hF, 1);
    step(0, 2'd0, 32'h0, 4'h0, 0);
    idle();
    chk("R10 only written slot commits", {28'd0, sw_e}, 32'h1);
    chk("R10 other slot untouched", hv_e[63:32], 32'h5566_CCDD);

    step(1, 2'd3, 32'h0000_0077, 4'b0001, 1);
    idle();
    chk("R4 strobed trigger reg", hv_r[127:96], 32'hCAFE_0077);
    chk("R6 two pending commit", {28'd0, sw_r}, 32'hD);

    step(0, 2'd1, 32'h0, 4'h0, 1);
    idle();
    chk("R11 read data", rd_r, 32'h5566_CCDD);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[3:2], $urandom, r[7:4], (r[10:8] != 3'd0));
    end
    idle();
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule